// File: doc/BRIEF.md
# Dead-Block Correlating Prefetch Predictor

This block watches the stream of L1 data accesses and predicts the moment a cache frame has received its final use. It also predicts which block address will miss next in that frame. For every frame it keeps a running signature, held in a table that shadows the L1 tag array. A fill starts the signature as the sum of the block address and the PC of the miss. Every later hit adds its PC, and the sum is truncated to a fixed width.

A shared, direct-mapped correlation table is indexed by signature. Each entry holds a tag, the address that followed that signature the last time, and a two-bit confidence counter. When the signature updated by an access meets a confident entry, the block asks the cache to evict the frame early and issues a prefetch for the stored address. Each miss into a frame trains the entry of the signature that the frame carried before the miss.

The cache itself sends the access stream: valid, hit/miss, frame number, PC and block address. The block answers one cycle later with an evict request and a prefetch request. The data array and the fill path are not part of this block.

Top module: `dbp_predictor`

## Requirements
- R1: After reset, both request outputs are low, every frame is untracked and every correlation entry is invalid.
- R2: A miss into frame f makes f tracked and not dead, and sets its signature to (addr[15:0] + pc[15:0]) mod 2^16.
- R3: A hit into a tracked frame adds pc[15:0] to its signature mod 2^16. A hit into an untracked frame has no effect and makes no prediction. A cycle with acc_valid_i low changes nothing.
- R4: The correlation table is direct-mapped with 64 entries. Signature bits [5:0] select the entry and bits [15:6] are stored and compared as its tag. One entry serves every frame.
- R5: A miss into a tracked frame trains the entry of that frame's previous signature. If the entry is valid, has the same tag and stores the new miss address, its counter increases and saturates at 3. Otherwise the entry is rewritten with the new tag and address and its counter set to 0.
- R6: The block predicts when an access leaves a frame with a signature whose entry is valid, has the matching tag and holds a counter of at least 2. One cycle after that access, evict_valid_o and pf_valid_o are high together, with the frame number and the stored address. The lookup uses the table as it stood before any training caused by the same access.
- R7: An entry whose counter is 0 or 1 never causes a prediction.
- R8: Once a frame has been predicted dead, later hits into it make no further prediction until the next miss into that frame.
- R9: The request outputs are single-cycle pulses. Each access gives at most one prediction, and no prediction follows a cycle without an access.
- R10: A miss can train one entry and predict from another in the same cycle. The fill itself is then treated as the last touch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid_i | input | 1 | An L1 access is presented this cycle |
| acc_hit_i | input | 1 | 1 = hit, 0 = miss (fill into the frame) |
| acc_frame_i | input | 4 | L1 frame touched by the access |
| acc_pc_i | input | 32 | PC of the accessing instruction |
| acc_addr_i | input | 32 | Block address of the access |
| evict_valid_o | output | 1 | Request to evict a frame predicted dead |
| evict_frame_o | output | 4 | Frame to evict |
| pf_valid_o | output | 1 | Prefetch request |
| pf_addr_o | output | 32 | Block address to prefetch |

## Verification
On a miss, the block both trains the entry of the frame's old signature and looks up the entry of the fresh signature, and both happen in one cycle. The bench provokes this by repeating a trace in which a frame is filled and then replaced with no hits in between, so that the fill itself becomes the last touch. It then checks that the prediction appears in the cycle after the miss while the training still takes effect. A second case sets up signatures whose entry indices coincide, to show that the lookup reads the table from before the same-cycle training. The bench keeps an independent model of the requirements and compares its expected evict and prefetch outputs with those of the block on every cycle.

// File: rtl/dbp_pkg.sv
package dbp_pkg;
    parameter int ADDR_W = 32;
    parameter int PC_W   = 32;
    parameter int SIG_W  = 16;
    parameter logic [1:0] CONF_MIN = 2'd2;

    typedef logic [SIG_W-1:0] sig_t;

    // Truncation used by the signature sum: keep the low bits only.
    function automatic sig_t fold_addr(input logic [ADDR_W-1:0] a);
        return a[SIG_W-1:0];
    endfunction

    function automatic sig_t fold_pc(input logic [PC_W-1:0] p);
        return p[SIG_W-1:0];
    endfunction
endpackage

// File: rtl/dbp_history.sv
module dbp_history
    import dbp_pkg::*;
#(
    parameter int FRAMES  = 16,
    parameter int FRAME_W = $clog2(FRAMES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc_valid_i,
    input  logic               acc_hit_i,
    input  logic [FRAME_W-1:0] acc_frame_i,
    input  logic [PC_W-1:0]    acc_pc_i,
    input  logic [ADDR_W-1:0]  acc_addr_i,
    input  logic               mark_dead_i,
    output sig_t               old_sig_o,
    output logic               old_valid_o,
    output logic               cur_dead_o,
    output sig_t               new_sig_o,
    output logic [FRAMES-1:0]  dead_vec_o
);
    typedef struct packed {
        logic [FRAMES-1:0] vld;
        logic [FRAMES-1:0] dead;
        sig_t [FRAMES-1:0] sig;
    } hist_st_t;

    hist_st_t st_d, st_q;

    always_comb begin
        old_sig_o   = st_q.sig[acc_frame_i];
        old_valid_o = st_q.vld[acc_frame_i];
        cur_dead_o  = st_q.dead[acc_frame_i];
        if (acc_hit_i) new_sig_o = old_sig_o + fold_pc(acc_pc_i);
        else           new_sig_o = fold_addr(acc_addr_i) + fold_pc(acc_pc_i);

        st_d = st_q;
        if (acc_valid_i) begin
            if (!acc_hit_i) begin
                st_d.vld[acc_frame_i]  = 1'b1;
                st_d.dead[acc_frame_i] = 1'b0;
                st_d.sig[acc_frame_i]  = new_sig_o;
            end else if (old_valid_o) begin
                st_d.sig[acc_frame_i]  = new_sig_o;
            end
            if (mark_dead_i) st_d.dead[acc_frame_i] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dead_vec_o = st_q.dead;

    // R2
    fill_clears_dead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid_i && !acc_hit_i && !mark_dead_i) |=> !st_q.dead[$past(acc_frame_i)] && st_q.vld[$past(acc_frame_i)]);

    // R3
    untracked_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid_i && acc_hit_i && !old_valid_o) |=> $stable(st_q.vld) && $stable(st_q.sig));
endmodule

// File: rtl/dbp_corr.sv
module dbp_corr
    import dbp_pkg::*;
#(
    parameter int ENTRIES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  sig_t              lk_sig_i,
    output logic              lk_conf_o,
    output logic [ADDR_W-1:0] lk_addr_o,
    input  logic              tr_en_i,
    input  sig_t              tr_sig_i,
    input  logic [ADDR_W-1:0] tr_addr_i
);
    localparam int IDX_W = $clog2(ENTRIES);
    localparam int TAG_W = SIG_W - IDX_W;

    typedef struct packed {
        logic              vld;
        logic [TAG_W-1:0]  tag;
        logic [ADDR_W-1:0] nxt;
        logic [1:0]        cnt;
    } ent_t;

    typedef struct packed {
        ent_t [ENTRIES-1:0] ent;
    } corr_st_t;

    corr_st_t st_d, st_q;

    logic [IDX_W-1:0] lk_idx, tr_idx;
    logic [TAG_W-1:0] lk_tag, tr_tag;
    ent_t             lk_e, tr_e;
    logic             tr_match;

    always_comb begin
        lk_idx = lk_sig_i[IDX_W-1:0];
        lk_tag = lk_sig_i[SIG_W-1:IDX_W];
        tr_idx = tr_sig_i[IDX_W-1:0];
        tr_tag = tr_sig_i[SIG_W-1:IDX_W];

        lk_e      = st_q.ent[lk_idx];
        lk_conf_o = lk_e.vld && (lk_e.tag == lk_tag) && (lk_e.cnt >= CONF_MIN);
        lk_addr_o = lk_e.nxt;

        tr_e     = st_q.ent[tr_idx];
        tr_match = tr_e.vld && (tr_e.tag == tr_tag) && (tr_e.nxt == tr_addr_i);

        st_d = st_q;
        if (tr_en_i) begin
            if (tr_match) begin
                if (tr_e.cnt != 2'd3) st_d.ent[tr_idx].cnt = tr_e.cnt + 2'd1;
            end else begin
                st_d.ent[tr_idx].vld = 1'b1;
                st_d.ent[tr_idx].tag = tr_tag;
                st_d.ent[tr_idx].nxt = tr_addr_i;
                st_d.ent[tr_idx].cnt = 2'd0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R5
    saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tr_en_i && tr_match && tr_e.cnt == 2'd3) |=> st_q.ent[$past(tr_idx)].cnt == 2'd3);

    // R5
    retrain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tr_en_i && !tr_match) |=> st_q.ent[$past(tr_idx)].vld && st_q.ent[$past(tr_idx)].cnt == 2'd0
                                   && st_q.ent[$past(tr_idx)].nxt == $past(tr_addr_i));
endmodule

// File: rtl/dbp_predictor.sv
module dbp_predictor
    import dbp_pkg::*;
#(
    parameter int FRAMES     = 16,
    parameter int CT_ENTRIES = 64,
    parameter int FRAME_W    = $clog2(FRAMES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc_valid_i,
    input  logic               acc_hit_i,
    input  logic [FRAME_W-1:0] acc_frame_i,
    input  logic [PC_W-1:0]    acc_pc_i,
    input  logic [ADDR_W-1:0]  acc_addr_i,
    output logic               evict_valid_o,
    output logic [FRAME_W-1:0] evict_frame_o,
    output logic               pf_valid_o,
    output logic [ADDR_W-1:0]  pf_addr_o
);
    typedef struct packed {
        logic               ev_v;
        logic [FRAME_W-1:0] ev_fr;
        logic               pf_v;
        logic [ADDR_W-1:0]  pf_a;
    } out_st_t;

    out_st_t out_d, out_q;

    sig_t              old_sig, new_sig;
    logic              old_valid, cur_dead, lk_conf, predict, train_en;
    logic [ADDR_W-1:0] lk_addr;
    logic [FRAMES-1:0] dead_vec;

    dbp_history #(.FRAMES(FRAMES), .FRAME_W(FRAME_W)) hist_i (
        .clk(clk), .rst_n(rst_n),
        .acc_valid_i(acc_valid_i), .acc_hit_i(acc_hit_i), .acc_frame_i(acc_frame_i),
        .acc_pc_i(acc_pc_i), .acc_addr_i(acc_addr_i), .mark_dead_i(predict),
        .old_sig_o(old_sig), .old_valid_o(old_valid), .cur_dead_o(cur_dead),
        .new_sig_o(new_sig), .dead_vec_o(dead_vec)
    );

    dbp_corr #(.ENTRIES(CT_ENTRIES)) corr_i (
        .clk(clk), .rst_n(rst_n),
        .lk_sig_i(new_sig), .lk_conf_o(lk_conf), .lk_addr_o(lk_addr),
        .tr_en_i(train_en), .tr_sig_i(old_sig), .tr_addr_i(acc_addr_i)
    );

    always_comb begin
        train_en = acc_valid_i && !acc_hit_i && old_valid;
        predict  = acc_valid_i && lk_conf &&
                   (acc_hit_i ? (old_valid && !cur_dead) : 1'b1);
        out_d       = '0;
        out_d.ev_v  = predict;
        out_d.ev_fr = predict ? acc_frame_i : '0;
        out_d.pf_v  = predict;
        out_d.pf_a  = predict ? lk_addr : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign evict_valid_o = out_q.ev_v;
    assign evict_frame_o = out_q.ev_fr;
    assign pf_valid_o    = out_q.pf_v;
    assign pf_addr_o     = out_q.pf_a;

    // R8
    dead_marked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid_o |-> dead_vec[evict_frame_o]);

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid_i |=> !pf_valid_o && !evict_valid_o);

    // R6
    paired_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evict_valid_o |-> pf_valid_o && $past(acc_valid_i) && evict_frame_o == $past(acc_frame_i));
endmodule

// File: tb/dbp_predictor_tb_top.sv
module dbp_predictor_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid_i = 1'b0;
    logic        acc_hit_i = 1'b0;
    logic [3:0]  acc_frame_i = '0;
    logic [31:0] acc_pc_i = '0;
    logic [31:0] acc_addr_i = '0;
    logic        evict_valid_o, pf_valid_o;
    logic [3:0]  evict_frame_o;
    logic [31:0] pf_addr_o;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    dbp_predictor dut_i (
        .clk(clk), .rst_n(rst_n),
        .acc_valid_i(acc_valid_i), .acc_hit_i(acc_hit_i), .acc_frame_i(acc_frame_i),
        .acc_pc_i(acc_pc_i), .acc_addr_i(acc_addr_i),
        .evict_valid_o(evict_valid_o), .evict_frame_o(evict_frame_o),
        .pf_valid_o(pf_valid_o), .pf_addr_o(pf_addr_o)
    );

    typedef struct {
        bit        v;
        bit [3:0]  fr;
        bit [31:0] a;
        string     req;
    } exp_t;

    exp_t exp_q[$];

    // Independent model of the requirements
    bit        m_vld[16];
    bit        m_dead[16];
    bit [15:0] m_sig[16];
    bit        c_vld[64];
    bit [9:0]  c_tag[64];
    bit [31:0] c_nxt[64];
    bit [1:0]  c_cnt[64];

    task automatic access(input bit valid, input bit hit, input bit [3:0] f,
                          input bit [31:0] pc, input bit [31:0] addr, input string req);
        exp_t e;
        bit [15:0] nsig;
        bit live, conf;
        @(negedge clk);
        acc_valid_i = valid; acc_hit_i = hit; acc_frame_i = f;
        acc_pc_i = pc; acc_addr_i = addr;
        e.v = 0; e.fr = '0; e.a = '0; e.req = req;
        if (valid) begin
            nsig = hit ? m_sig[f] + pc[15:0] : addr[15:0] + pc[15:0];
            live = hit ? (m_vld[f] && !m_dead[f]) : 1'b1;
            conf = c_vld[nsig[5:0]] && c_tag[nsig[5:0]] == nsig[15:6] && c_cnt[nsig[5:0]] >= 2;
            if (live && conf) begin
                e.v = 1; e.fr = f; e.a = c_nxt[nsig[5:0]];
            end
            if (!hit && m_vld[f]) begin
                int ti = int'(m_sig[f][5:0]);
                if (c_vld[ti] && c_tag[ti] == m_sig[f][15:6] && c_nxt[ti] == addr) begin
                    if (c_cnt[ti] != 2'd3) c_cnt[ti] = c_cnt[ti] + 2'd1;
                end else begin
                    c_vld[ti] = 1; c_tag[ti] = m_sig[f][15:6]; c_nxt[ti] = addr; c_cnt[ti] = 0;
                end
            end
            if (!hit) begin
                m_vld[f] = 1; m_dead[f] = 0; m_sig[f] = nsig;
            end else if (m_vld[f]) begin
                m_sig[f] = nsig;
            end
            if (e.v) m_dead[f] = 1;
        end
        exp_q.push_back(e);
    endtask

    // Monitor: compare one expectation per clock edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                total++;
                if (evict_valid_o !== e.v || pf_valid_o !== e.v ||
                    (e.v && (evict_frame_o !== e.fr || pf_addr_o !== e.a))) begin
                    bad++;
                    $display("FAIL %s: got ev=%0b fr=%0d pf=%0b a=%h, expected ev=pf=%0b fr=%0d a=%h",
                             e.req, evict_valid_o, evict_frame_o, pf_valid_o, pf_addr_o,
                             e.v, e.fr, e.a);
                end
            end
        end
    end

    initial begin
        #4000000;
        bad++;
        total++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    localparam bit [31:0] A_ADR = 32'h1000_0040;
    localparam bit [31:0] B_ADR = 32'h2000_0080;
    localparam bit [31:0] C_ADR = 32'h2000_00C4;
    localparam bit [31:0] X_ADR = 32'h3000_0100;
    localparam bit [31:0] Y_ADR = 32'h3000_0210;

    initial begin
        for (int i = 0; i < 16; i++) begin m_vld[i] = 0; m_dead[i] = 0; m_sig[i] = 0; end
        for (int i = 0; i < 64; i++) begin c_vld[i] = 0; c_tag[i] = 0; c_nxt[i] = 0; c_cnt[i] = 0; end
        repeat (3) @(posedge clk);
        #2;
        total++;
        if (evict_valid_o !== 1'b0 || pf_valid_o !== 1'b0) begin
            bad++;
            $display("FAIL R1: got ev=%0b pf=%0b, expected 0 0", evict_valid_o, pf_valid_o);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R1: untrained table after reset gives nothing; R2/R3/R5/R6/R7 trained by repetition
        for (int it = 0; it < 6; it++) begin
            access(1, 0, 4'd1, 32'h400, A_ADR, "R2");
            access(1, 1, 4'd1, 32'h404, A_ADR, "R3");
            access(1, 1, 4'd1, 32'h408, A_ADR, it < 3 ? "R7" : "R6");
            if (it == 5) access(1, 1, 4'd1, 32'h0, A_ADR, "R8");   // same signature, frame already dead
            if (it == 5) access(1, 1, 4'd1, 32'h0, A_ADR, "R8");
            access(1, 0, 4'd1, 32'h500, B_ADR, "R5");
            access(1, 1, 4'd1, 32'h504, B_ADR, "R6");
        end

        // R5: different next miss rewrites the entry, confidence lost
        access(1, 0, 4'd1, 32'h400, A_ADR, "R5");
        access(1, 1, 4'd1, 32'h404, A_ADR, "R5");
        access(1, 1, 4'd1, 32'h408, A_ADR, "R5");
        access(1, 0, 4'd1, 32'h500, C_ADR, "R5");
        access(1, 0, 4'd1, 32'h400, A_ADR, "R5");
        access(1, 1, 4'd1, 32'h404, A_ADR, "R5");
        access(1, 1, 4'd1, 32'h408, A_ADR, "R7");
        access(1, 0, 4'd1, 32'h500, B_ADR, "R5");

        // R10: fill is the last touch, training and predicting in one cycle
        for (int it = 0; it < 6; it++) begin
            access(1, 0, 4'd2, 32'h600, X_ADR, "R10");
            access(1, 0, 4'd2, 32'h700, Y_ADR, "R10");
        end

        // R3: hit into untracked frame whose would-be signature is confident
        access(1, 1, 4'd9, 32'h0700, X_ADR, "R3");
        // R9: no access, values that would otherwise predict
        access(0, 0, 4'd2, 32'h600, X_ADR, "R9");
        access(0, 1, 4'd2, 32'h0, X_ADR, "R9");
        // R4: same index, different tag
        access(1, 0, 4'd3, 32'h600, 32'h0000_0140, "R4");
        // R4: same signature from another frame shares the entry
        access(1, 0, 4'd4, 32'h600, X_ADR, "R4");
        // R8: later hit with unchanged signature stays quiet; a fresh miss re-arms
        access(1, 1, 4'd4, 32'h0, X_ADR, "R8");
        access(1, 0, 4'd4, 32'h600, X_ADR, "R8");
        access(0, 0, 4'd0, 32'h0, 32'h0, "R9");
        access(0, 0, 4'd0, 32'h0, 32'h0, "R9");

        repeat (3) @(posedge clk);
        #5;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule